// File: doc/BRIEF.md
# Limb-Serial Scalar Multiply-Accumulate Engine

This block multiplies an unsigned integer stored as a sequence of limbs by a single scalar limb. It walks the limbs from least to most significant, one per clock once its read pipeline is full. For each limb it forms the double-width value `limb * scalar + carry`. The lower half is written back as the result limb at the same index. The upper half is held inside the engine and forwarded into the next step, so no half of any product is thrown away.

A caller loads the source limbs into a memory behind the read port and gives a start pulse with the limb count and the scalar. It then collects result limbs from the write port. When the count is used up, the last upper half appears on `carry_out` as the extra most significant limb of the product, and `done` is raised. The read port assumes a synchronous memory: data for an address issued in one cycle is presented in the next cycle.

Top module: `limb_mac_engine`

## Requirements
- R1: For every limb index i below the count, exactly one write goes to address i. Its data is the lower LIMB_W bits of src[i]*scalar + cin(i), computed at double width.
- R2: cin(0) is zero, whatever an earlier job left behind.
- R3: For i > 0, cin(i) is the upper LIMB_W bits of the double-width value formed at step i-1. This holds even when every limb and the scalar are all ones.
- R4: After the write of the last limb, `carry_out` holds the upper half of the last step and `done` is 1. `done` rises in the same cycle as that last write, and no read or write follows while `done` is held.
- R5: A start with a count of zero gives `done`=1 and `carry_out`=0 in the next cycle, with no read and no write.
- R6: A start with count N>0 issues exactly N reads. The first read comes in the cycle after the start and goes to address 0. The reads go one per cycle, each address one above the last.
- R7: Each write comes two cycles after the read of the same index. Write addresses rise by one each cycle, and exactly N writes occur.
- R8: A start pulse while a job is running is ignored: it adds no reads or writes and does not change the result or `carry_out`.
- R9: After reset, `done`, `rd_en` and `wr_en` are 0 and `carry_out` is 0.
- R10: An accepted start with count > 0 clears `done` in the next cycle. Otherwise `done` stays unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a job; taken only when idle |
| limb_count | input | ADDR_W+1 | Number of limbs, 0 to 2**ADDR_W |
| scalar | input | LIMB_W | Scalar multiplier, captured at start |
| rd_en | output | 1 | Read request to the source memory |
| rd_addr | output | ADDR_W | Source limb index |
| rd_data | input | LIMB_W | Source limb, valid the cycle after a read request |
| wr_en | output | 1 | Result limb write strobe |
| wr_addr | output | ADDR_W | Result limb index |
| wr_data | output | LIMB_W | Result limb |
| carry_out | output | LIMB_W | Final upper half, the extra most significant limb |
| done | output | 1 | Job finished; held until the next accepted start |

## Verification
The bench builds the engine with LIMB_W=64 and ADDR_W=4. At 64 bits, all-ones limbs and an all-ones scalar push each step's double-width sum to its largest value, so a wrong forwarded carry or a truncated product shows up directly. The sixteen-entry depth is small enough that the count can reach full depth, including the count width's top bit. Jobs that run back to back, a zero count and a start issued mid-job are all covered against a scoreboard of expected writes.

// File: rtl/limb_mac_pkg.sv
package limb_mac_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

endpackage

// File: rtl/limb_mac_step.sv
module limb_mac_step #(
  parameter int LIMB_W = 64
) (
  input  logic [LIMB_W-1:0] limb,
  input  logic [LIMB_W-1:0] mult,
  input  logic [LIMB_W-1:0] cin,
  output logic [LIMB_W-1:0] lo,
  output logic [LIMB_W-1:0] hi
);

  localparam int PW = 2 * LIMB_W;

  logic [PW-1:0] prod;
  logic [PW-1:0] sum;

  // Double-width product plus carry limb; the largest possible sum still fits in PW bits
  always_comb begin
    prod = PW'(limb) * PW'(mult);
    sum  = prod + PW'(cin);
    lo   = sum[LIMB_W-1:0];
    hi   = sum[PW-1:LIMB_W];
  end

endmodule

// File: rtl/limb_mac_seq.sv
module limb_mac_seq
  import limb_mac_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  output logic              start_go,
  output logic              zero_go,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              step_fire,
  output logic [CNT_W-1:0]  step_idx,
  output logic              step_first,
  output logic              step_last
);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] iss_q;
  logic             rd_en_q;
  logic [CNT_W-1:0] rd_idx_q;
  logic             dv_q;
  logic [CNT_W-1:0] dv_idx_q;

  always_comb begin
    start_go   = (state_q == SEQ_IDLE) && start;
    zero_go    = start_go && (count == '0);
    step_fire  = dv_q;
    step_idx   = dv_idx_q;
    step_first = dv_q && (dv_idx_q == '0);
    step_last  = dv_q && (dv_idx_q == cnt_q - CNT_W'(1));
    rd_en      = rd_en_q;
    rd_addr    = rd_idx_q[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      iss_q    <= '0;
      rd_en_q  <= 1'b0;
      rd_idx_q <= '0;
      dv_q     <= 1'b0;
      dv_idx_q <= '0;
    end else begin
      // data for the index requested last cycle arrives this cycle
      dv_q     <= rd_en_q;
      dv_idx_q <= rd_idx_q;
      case (state_q)
        SEQ_IDLE: begin
          rd_en_q <= 1'b0;
          if (start_go && !zero_go) begin
            state_q  <= SEQ_RUN;
            cnt_q    <= count;
            rd_en_q  <= 1'b1;
            rd_idx_q <= '0;
            iss_q    <= CNT_W'(1);
          end
        end
        SEQ_RUN: begin
          if (iss_q < cnt_q) begin
            rd_en_q  <= 1'b1;
            rd_idx_q <= iss_q;
            iss_q    <= iss_q + CNT_W'(1);
          end else begin
            rd_en_q  <= 1'b0;
          end
          if (step_last) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_first_read_R6: assert property (@(posedge clk) disable iff (rst)
    (start_go && !zero_go) |=> (rd_en_q && rd_idx_q == '0));

  assert_read_ascending_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en_q && $past(rd_en_q)) |-> (rd_idx_q == $past(rd_idx_q) + CNT_W'(1)));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_RUN && start) |=> !(rd_en_q && rd_idx_q == '0));

  assert_read_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en_q |-> (rd_idx_q < cnt_q));

endmodule

// File: rtl/limb_mac_wb.sv
module limb_mac_wb #(
  parameter int LIMB_W = 64,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_go,
  input  logic              zero_go,
  input  logic [LIMB_W-1:0] scalar,
  input  logic              step_fire,
  input  logic [CNT_W-1:0]  step_idx,
  input  logic              step_first,
  input  logic              step_last,
  input  logic [LIMB_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LIMB_W-1:0] wr_data,
  output logic [LIMB_W-1:0] carry_out,
  output logic              done
);

  logic [LIMB_W-1:0] scalar_q;
  logic [LIMB_W-1:0] carry_q;
  logic [LIMB_W-1:0] cin;
  logic [LIMB_W-1:0] lo;
  logic [LIMB_W-1:0] hi;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [LIMB_W-1:0] wr_data_q;
  logic [LIMB_W-1:0] cout_q;
  logic              done_q;

  // the first step of a job takes zero regardless of the held carry
  always_comb cin = step_first ? '0 : carry_q;

  limb_mac_step #(.LIMB_W(LIMB_W)) u_step (
    .limb (rd_data),
    .mult (scalar_q),
    .cin  (cin),
    .lo   (lo),
    .hi   (hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scalar_q  <= '0;
      carry_q   <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      cout_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      wr_en_q <= step_fire;
      if (start_go) begin
        scalar_q <= scalar;
        cout_q   <= '0;
        done_q   <= zero_go;
      end
      if (step_fire) begin
        wr_addr_q <= step_idx[ADDR_W-1:0];
        wr_data_q <= lo;
        carry_q   <= hi;
        if (step_last) begin
          cout_q <= hi;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    wr_en     = wr_en_q;
    wr_addr   = wr_addr_q;
    wr_data   = wr_data_q;
    carry_out = cout_q;
    done      = done_q;
  end

  assert_done_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (done_q && $past(done_q)) |-> !wr_en_q);

  assert_write_ascending_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en_q && $past(wr_en_q)) |-> (wr_addr_q == $past(wr_addr_q) + ADDR_W'(1)));

endmodule

// File: rtl/limb_mac_engine.sv
module limb_mac_engine #(
  parameter int LIMB_W = 64,
  parameter int ADDR_W = 4,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  limb_count,
  input  logic [LIMB_W-1:0] scalar,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [LIMB_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LIMB_W-1:0] wr_data,
  output logic [LIMB_W-1:0] carry_out,
  output logic              done
);

  logic             start_go;
  logic             zero_go;
  logic             step_fire;
  logic [CNT_W-1:0] step_idx;
  logic             step_first;
  logic             step_last;

  limb_mac_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .count      (limb_count),
    .start_go   (start_go),
    .zero_go    (zero_go),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .step_fire  (step_fire),
    .step_idx   (step_idx),
    .step_first (step_first),
    .step_last  (step_last)
  );

  limb_mac_wb #(.LIMB_W(LIMB_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wb (
    .clk        (clk),
    .rst        (rst),
    .start_go   (start_go),
    .zero_go    (zero_go),
    .scalar     (scalar),
    .step_fire  (step_fire),
    .step_idx   (step_idx),
    .step_first (step_first),
    .step_last  (step_last),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .carry_out  (carry_out),
    .done       (done)
  );

  assert_write_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rd_en, 2));

  assert_zero_count_R5: assert property (@(posedge clk) disable iff (rst)
    zero_go |=> (done && !wr_en && !rd_en && carry_out == '0));

  assert_done_with_last_write_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (wr_en || $past(zero_go)));

endmodule

// File: tb/limb_mac_engine_tb.sv
module limb_mac_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LIMB_W = 64;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = ADDR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic [ADDR_W-1:0] a;
    logic [LIMB_W-1:0] d;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  limb_count = '0;
  logic [LIMB_W-1:0] scalar = '0;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [LIMB_W-1:0] rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [LIMB_W-1:0] wr_data;
  logic [LIMB_W-1:0] carry_out;
  logic              done;

  logic [LIMB_W-1:0] src [DEPTH];
  exp_t              sb [$];
  exp_t              e_pop;
  logic [LIMB_W-1:0] exp_carry;
  int                rd_exp = 0;
  int                n_cmp = 0;
  int                n_bad = 0;
  bit                ended = 1'b0;
  logic [63:0]       lcg = 64'h0123456789abcdef;

  always #(CLK_PERIOD/2) clk = ~clk;

  limb_mac_engine #(.LIMB_W(LIMB_W), .ADDR_W(ADDR_W)) u_dut (
    .clk (clk), .rst (rst), .start (start), .limb_count (limb_count),
    .scalar (scalar), .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .carry_out (carry_out), .done (done)
  );

  // synchronous-read source memory
  always_ff @(posedge clk) if (rd_en) rd_data <= src[rd_addr];

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] next_rand();
    lcg = lcg * 64'h5851f42d4c957f2d + 64'h14057b7ef767814f;
    return lcg;
  endfunction

  // monitor: reads in order, writes popped against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_en) begin
        chk(rd_addr == rd_exp[ADDR_W-1:0], "R6 read address", rd_addr, rd_exp);
        rd_exp++;
      end
      if (wr_en) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7/R8 unexpected write", wr_addr, 0);
        end else begin
          e_pop = sb.pop_front();
          chk(wr_addr == e_pop.a, "R7 write address", wr_addr, e_pop.a);
          chk(wr_data == e_pop.d, (e_pop.a == 0) ? "R2 first limb data" : "R1/R3 limb data",
              wr_data, e_pop.d);
        end
      end
    end
  end

  task automatic prep(input int n, input logic [LIMB_W-1:0] s);
    logic [127:0] acc;
    logic [LIMB_W-1:0] c;
    c = '0;
    for (int i = 0; i < n; i++) begin
      acc = {64'd0, src[i]} * {64'd0, s} + {64'd0, c};
      sb.push_back('{a: ADDR_W'(i), d: acc[63:0]});
      c = acc[127:64];
    end
    exp_carry = c;
    rd_exp = 0;
  endtask

  task automatic pulse(input int n, input logic [LIMB_W-1:0] s);
    @(negedge clk);
    limb_count = CNT_W'(n);
    scalar = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_job(input int n, input string name);
    int t = 0;
    while (!done && t < 200) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    chk(done, {"R4 done after ", name}, done, 1);
    chk(carry_out == exp_carry, {"R4 carry_out ", name}, carry_out, exp_carry);
    chk(sb.size() == 0, {"R7 write count ", name}, sb.size(), 0);
    chk(rd_exp == n, {"R6 read count ", name}, rd_exp, n);
  endtask

  task automatic run_job(input int n, input logic [LIMB_W-1:0] s, input string name);
    prep(n, s);
    pulse(n, s);
    if (n > 0) chk(!done, {"R10 done cleared ", name}, done, 0);
    else begin
      chk(done, "R5 zero count done", done, 1);
      chk(carry_out == '0, "R5 zero count carry", carry_out, 0);
    end
    finish_job(n, name);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) src[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!done, "R9 done after reset", done, 0);
    chk(!rd_en && !wr_en, "R9 strobes after reset", {rd_en, wr_en}, 0);
    chk(carry_out == '0, "R9 carry_out after reset", carry_out, 0);

    // R5 zero count from idle
    run_job(0, 64'h1234, "zero");

    // single limb
    src[0] = 64'd5;
    run_job(1, 64'd7, "single");

    // R3 worst case carries
    for (int i = 0; i < 4; i++) src[i] = '1;
    run_job(4, '1, "all-ones");

    // R1 two limbs with a carry of one
    run_job(2, 64'd2, "times-two");

    // full depth pseudo-random, started right after the last job
    for (int i = 0; i < DEPTH; i++) src[i] = next_rand();
    run_job(DEPTH, next_rand(), "full-depth");

    // scalar zero and one
    run_job(5, '0, "scalar-zero");
    run_job(5, 64'd1, "scalar-one");

    // R8 start while running is ignored
    for (int i = 0; i < DEPTH; i++) src[i] = next_rand();
    prep(8, 64'hfedcba9876543210);
    pulse(8, 64'hfedcba9876543210);
    @(negedge clk);
    limb_count = CNT_W'(3);
    scalar = 64'd99;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_job(8, "busy-restart R8");
    repeat (6) @(negedge clk);
    chk(done, "R8 done held after ignored start", done, 1);
    chk(carry_out == exp_carry, "R8 carry_out unchanged", carry_out, exp_carry);
    chk(rd_exp == 8, "R8 no extra reads", rd_exp, 8);

    // R10 done holds while idle, R2 first carry zero after a large carry
    for (int i = 0; i < 3; i++) src[i] = '1;
    run_job(3, '1, "carry-rich");
    src[0] = 64'd3;
    run_job(1, 64'd4, "after-carry R2");

    // R5 zero count after a nonzero job clears carry_out
    run_job(0, 64'd9, "zero-again");

    repeat (3) @(negedge clk);
    summary();
  end

endmodule